// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation converter. It runs from one main clock. A start request, one clock period long and picked up on the falling clock edge, launches a conversion. The sequencer first waits a short fixed settling interval. It then resolves the result one bit at a time, from the most significant bit down. For each bit it presents a trial code to an external resistor-string DAC, waits for the DAC to settle, and samples a single comparator decision. The decision either keeps or drops the trial bit.

A status flag is low while a conversion runs and high otherwise. An active-high standby input cancels any conversion in progress, holds the engine idle, and raises the flag at once through a purely combinational path. A read strobe drives an 8-bit bus with an output enable. While a conversion runs, the bus carries the identifier of the selected analog input, so the input selection can be confirmed. Once the flag is high, the bus carries the last completed result.

The analog comparator, the DAC, calibration and power control sit outside this block.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, status_o is 1, dac_code_o is 0, bus_oe_o is 0, and the stored result is 0.
- R2: start_i is sampled on the falling clock edge. A one-period pulse seen there while idle and not in standby starts a conversion at the next rising edge, and status_o goes low after that edge. A pulse that no falling edge sees has no effect.
- R3: Once started, status_o stays low for exactly 37 clock cycles (a 5-cycle settle followed by 8 trials of 4 cycles) and then returns high.
- R4: dac_code_o is 0 while idle and during the 5 settle cycles. During the trial for bit b it equals the bits already resolved above b, with bit b set and the bits below b cleared. This value holds for all 4 cycles of the trial.
- R5: The comparator input cmp_i is sampled at the end of the 4th cycle of each trial. A 1 keeps the trial bit and a 0 clears it.
- R6: With an ideal comparator (cmp_i = 1 when the analog level is at or above dac_code_o), the result equals the target code for every value from 0 to 255. It is therefore monotonic with no missing codes.
- R7: A start pulse that arrives while a conversion is running is ignored. The conversion still ends on schedule and no new one follows.
- R8: A start pulse that arrives while stby_i is high is ignored, and status_o stays high after standby ends.
- R9: stby_i high forces status_o high with no wait for a clock edge. It cancels the conversion, so dac_code_o is 0 from the next rising edge. A later start works normally.
- R10: The stored result changes only when all 8 bits have been resolved. A cancelled conversion leaves the previous result in place.
- R11: With rd_en_i high and status_o low, bus_oe_o is 1 and bus_o is {5'b0, sel_id_i}, with the identifier on bits [2:0].
- R12: With rd_en_i high and status_o high, bus_oe_o is 1 and bus_o is the stored result. With rd_en_i low, bus_oe_o is 0 and bus_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stby_i | input | 1 | Standby, active high: cancels and holds the engine |
| start_i | input | 1 | Conversion start pulse, sampled on the falling edge |
| cmp_i | input | 1 | Comparator decision, 1 when the input is at or above the DAC level |
| rd_en_i | input | 1 | Read strobe for the output bus |
| sel_id_i | input | 3 | Identifier of the selected analog input |
| dac_code_o | output | 8 | Trial code sent to the DAC |
| status_o | output | 1 | High when idle or in standby, low while converting |
| bus_o | output | 8 | Read data (input identifier or result) |
| bus_oe_o | output | 1 | Drive enable for the tri-state output pads |

## Verification
A sequencing fault inside the engine shows up at dac_code_o first. A miscounted settle or trial cycle, a wrong bit index, or a decision applied at the wrong time changes the trial code in the very cycle the fault occurs. The reference model compares dac_code_o every cycle, so the fault is caught there and does not wait for the final result. A fault in the result register, in the cancel path, or in the read selection can only be seen through the read bus, so the bus is read straight after each conversion, after each cancel, and during a running conversion.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_TRIAL  = 2'd2
  } phase_e;

  // Width of the shared cycle counter covering both the settle and the trial lengths.
  function automatic int cnt_width(int settle_cyc, int trial_cyc);
    int m;
    m = (settle_cyc > trial_cyc) ? settle_cyc : trial_cyc;
    return (m <= 2) ? 1 : $clog2(m);
  endfunction

  // Total busy cycles of one conversion.
  function automatic int conv_cycles(int data_w, int settle_cyc, int trial_cyc);
    return settle_cyc + data_w * trial_cyc;
  endfunction

endpackage

// File: rtl/sar_seq_timer.sv
`timescale 1ns/1ps
module sar_seq_timer
  import sar_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 5,
  parameter int TRIAL_CYC  = 4,
  parameter int CNT_W      = 3,
  parameter int BIT_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic             abort_i,
  output logic             busy_o,
  output logic             trial_on_o,
  output logic [BIT_W-1:0] trial_bit_o,
  output logic             sample_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] TRIAL_END  = CNT_W'(TRIAL_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_TOP    = BIT_W'(DATA_W - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BIT_W-1:0] bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
    end else if (abort_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (launch_i) begin
            ph_q  <= PH_SETTLE;
            cnt_q <= '0;
          end
        end
        PH_SETTLE: begin
          if (cnt_q == SETTLE_END) begin
            ph_q  <= PH_TRIAL;
            cnt_q <= '0;
            bit_q <= BIT_TOP;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        PH_TRIAL: begin
          if (cnt_q == TRIAL_END) begin
            cnt_q <= '0;
            if (bit_q == '0) ph_q <= PH_IDLE;
            else             bit_q <= bit_q - BIT_W'(1);
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o      = (ph_q != PH_IDLE);
  assign trial_on_o  = (ph_q == PH_TRIAL);
  assign trial_bit_o = bit_q;
  assign sample_o    = trial_on_o && (cnt_q == TRIAL_END);
  assign last_o      = sample_o && (bit_q == '0);

endmodule

// File: rtl/sar_seq_sar.sv
`timescale 1ns/1ps
module sar_seq_sar #(
  parameter int DATA_W = 8,
  parameter int BIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              abort_i,
  input  logic              busy_i,
  input  logic              trial_on_i,
  input  logic [BIT_W-1:0]  trial_bit_i,
  input  logic              sample_i,
  input  logic              last_i,
  input  logic              cmp_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o
);

  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] res_q;
  logic [DATA_W-1:0] trial_mask;

  // One-hot mask of the bit under trial.
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign trial_mask[i] = trial_on_i && (trial_bit_i == BIT_W'(i));
  end

  assign done_o = last_i && !abort_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (abort_i || launch_i) begin
      acc_q <= '0;
    end else if (sample_i) begin
      acc_q[trial_bit_i] <= cmp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (done_o) res_q <= {acc_q[DATA_W-1:1], cmp_i};
  end

  assign dac_code_o = busy_i ? (acc_q | trial_mask) : '0;
  assign result_o   = res_q;

endmodule

// File: rtl/sar_seq_rdmux.sv
`timescale 1ns/1ps
module sar_seq_rdmux #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              rd_en_i,
  input  logic              show_result_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [SEL_W-1:0]  sel_id_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o
);

  logic [DATA_W-1:0] sel_ext;

  assign sel_ext  = DATA_W'(sel_id_i);
  assign bus_oe_o = rd_en_i;

  always_comb begin
    if (!rd_en_i)          bus_o = '0;
    else if (show_result_i) bus_o = result_i;
    else                    bus_o = sel_ext;
  end

endmodule

// File: rtl/sar_seq_top.sv
`timescale 1ns/1ps
module sar_seq_top #(
  parameter int DATA_W     = 8,
  parameter int SETTLE_CYC = 5,
  parameter int TRIAL_CYC  = 4,
  parameter int SEL_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stby_i,
  input  logic              start_i,
  input  logic              cmp_i,
  input  logic              rd_en_i,
  input  logic [SEL_W-1:0]  sel_id_i,
  output logic [DATA_W-1:0] dac_code_o,
  output logic              status_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o
);

  localparam int BIT_W = (DATA_W <= 2) ? 1 : $clog2(DATA_W);
  localparam int CNT_W = sar_seq_pkg::cnt_width(SETTLE_CYC, TRIAL_CYC);

  logic             start_fall_q;
  logic             launch_w;
  logic             busy_w;
  logic             trial_on_w;
  logic [BIT_W-1:0] trial_bit_w;
  logic             sample_w;
  logic             last_w;
  logic             done_w;
  logic [DATA_W-1:0] result_w;

  // Start request captured on the falling clock edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) start_fall_q <= 1'b0;
    else        start_fall_q <= start_i;
  end

  assign launch_w = start_fall_q && !busy_w && !stby_i;
  assign status_o = !busy_w || stby_i;

  sar_seq_timer #(
    .DATA_W(DATA_W), .SETTLE_CYC(SETTLE_CYC), .TRIAL_CYC(TRIAL_CYC),
    .CNT_W(CNT_W), .BIT_W(BIT_W)
  ) timer_i (
    .clk(clk), .rst_n(rst_n), .launch_i(launch_w), .abort_i(stby_i),
    .busy_o(busy_w), .trial_on_o(trial_on_w), .trial_bit_o(trial_bit_w),
    .sample_o(sample_w), .last_o(last_w)
  );

  sar_seq_sar #(.DATA_W(DATA_W), .BIT_W(BIT_W)) sar_i (
    .clk(clk), .rst_n(rst_n), .launch_i(launch_w), .abort_i(stby_i),
    .busy_i(busy_w), .trial_on_i(trial_on_w), .trial_bit_i(trial_bit_w),
    .sample_i(sample_w), .last_i(last_w), .cmp_i(cmp_i),
    .dac_code_o(dac_code_o), .result_o(result_w), .done_o(done_w)
  );

  sar_seq_rdmux #(.DATA_W(DATA_W), .SEL_W(SEL_W)) rdmux_i (
    .rd_en_i(rd_en_i), .show_result_i(status_o), .result_i(result_w),
    .sel_id_i(sel_id_i), .bus_o(bus_o), .bus_oe_o(bus_oe_o)
  );

endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stby_i,
  input logic              rd_en_i,
  input logic [SEL_W-1:0]  sel_id_i,
  input logic              status_o,
  input logic [DATA_W-1:0] dac_code_o,
  input logic [DATA_W-1:0] bus_o,
  input logic              bus_oe_o,
  input logic [DATA_W-1:0] result_w,
  input logic              launch_w,
  input logic              done_w
);

  AST_DONE_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> status_o); // R3

  AST_SETTLE_DAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    launch_w |=> (dac_code_o == '0)); // R4

  AST_BUSY_NOT_RESTARTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_o && !done_w) |=> (!status_o || stby_i)); // R7

  AST_STBY_FLAG_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    stby_i |-> status_o); // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_w |=> $stable(result_w)); // R10

  AST_BUSY_READ_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !status_o) |-> (bus_oe_o && (bus_o == DATA_W'(sel_id_i)))); // R11

  AST_IDLE_READ_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && status_o) |-> (bus_oe_o && (bus_o == result_w))); // R12

endmodule

bind sar_seq_top sar_seq_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .stby_i(stby_i), .rd_en_i(rd_en_i),
  .sel_id_i(sel_id_i), .status_o(status_o), .dac_code_o(dac_code_o),
  .bus_o(bus_o), .bus_oe_o(bus_oe_o), .result_w(result_w),
  .launch_w(launch_w), .done_w(done_w)
);

// File: tb/sar_seq_top_tb_top.sv
`timescale 1ns/1ps
module sar_seq_top_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stby = 1'b0;
  logic       start = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [7:0] target = 8'd0;
  logic       cmp;
  logic [7:0] dac;
  logic       status;
  logic [7:0] bus;
  logic       bus_oe;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // Reference model state
  int m_cnt = -1;
  int m_acc = 0;
  int m_res = 0;
  bit m_sq = 1'b0;

  always #2 clk = ~clk;

  // Ideal behavioural comparator
  assign cmp = (target >= dac);

  sar_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .stby_i(stby), .start_i(start), .cmp_i(cmp),
    .rd_en_i(rd_en), .sel_id_i(sel), .dac_code_o(dac), .status_o(status),
    .bus_o(bus), .bus_oe_o(bus_oe)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int model_dac();
    if (m_cnt < 5) return 0;
    return m_acc | (1 << (7 - (m_cnt - 5) / 4));
  endfunction

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) m_sq = 1'b0;
    else        m_sq = start;
  end

  // Cycle model, then compare away from the edge
  always @(posedge clk) begin
    int t;
    bit exp_st;
    int exp_bus;
    if (!rst_n) begin
      m_cnt = -1; m_acc = 0; m_res = 0;
    end else if (stby) begin
      m_cnt = -1; m_acc = 0;
    end else if (m_cnt < 0) begin
      if (m_sq) begin m_cnt = 0; m_acc = 0; end
    end else begin
      if (m_cnt >= 5 && ((m_cnt - 5) % 4) == 3) begin
        t = model_dac();
        if (int'(target) >= t) m_acc = t;
      end
      if (m_cnt == 36) begin m_res = m_acc; m_cnt = -1; end
      else m_cnt++;
    end
    #3;
    exp_st  = (m_cnt < 0) || stby;
    exp_bus = !rd_en ? 0 : (exp_st ? m_res : int'(sel));
    chk(rst_n ? "R3 status" : "R1 status", int'(status), int'(exp_st));
    chk(rst_n ? "R4 dac" : "R1 dac", int'(dac), model_dac());
    chk("R12 enable", int'(bus_oe), int'(rd_en));
    chk((rd_en && !exp_st) ? "R11 bus" : "R12 bus", int'(bus), exp_bus);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic convert(logic [7:0] t);
    @(posedge clk); #1 target = t; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (38) @(posedge clk);
  endtask

  task automatic read_chk(string tag, int exp);
    @(posedge clk); #1 rd_en = 1'b1;
    #2;
    chk(tag, int'(bus), exp);
    chk(tag, int'(bus_oe), 1);
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  // Launch and look at dac_code_o in cycle k after the launch edge
  task automatic dac_at(string tag, logic [7:0] t, int k, int exp);
    @(posedge clk); #1 target = t; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (k) @(posedge clk);
    #2 chk(tag, int'(dac), exp);
    repeat (40) @(posedge clk);
  endtask

  // Measure busy length; optionally inject a second start at busy cycle inj
  task automatic measure(logic [7:0] t, int inj, output int n);
    n = 0;
    @(posedge clk); #1 target = t; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    forever begin
      #2;
      if (status) break;
      n++;
      @(posedge clk); #1 start = (n == inj);
    end
    start = 1'b0;
  endtask

  initial begin
    int n;
    int prev;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 status", int'(status), 1);
    chk("R1 dac", int'(dac), 0);
    chk("R1 enable", int'(bus_oe), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    read_chk("R1 result", 0);

    // R2: pulse that no falling edge sees
    @(posedge clk); #2.5 start = 1'b1;
    @(posedge clk); #0.5 start = 1'b0;
    repeat (3) @(posedge clk);
    #3 chk("R2 ignored short pulse", int'(status), 1);

    // R2 / R3: length of the busy window
    measure(8'd77, -1, n);
    chk("R2 launch", int'(n > 0), 1);
    chk("R3 busy cycles", n, 37);
    read_chk("R6 result", 77);

    // R4 / R5: trial codes and decision timing
    dac_at("R4 settle", 8'h80, 2, 0);
    dac_at("R4 first trial", 8'h80, 5, 8'h80);
    dac_at("R5 held to 4th cycle", 8'h7F, 8, 8'h80);
    dac_at("R5 bit kept", 8'h80, 9, 8'hC0);
    dac_at("R5 bit dropped", 8'h7F, 9, 8'h40);

    // R7: start during a conversion
    measure(8'd200, 10, n);
    chk("R7 busy cycles", n, 37);
    repeat (4) @(posedge clk);
    #3 chk("R7 no restart", int'(status), 1);
    read_chk("R7 result", 200);

    // R8: start during standby
    @(posedge clk); #1 stby = 1'b1; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    @(posedge clk); #1 stby = 1'b0;
    repeat (3) @(posedge clk);
    #3 chk("R8 start ignored", int'(status), 1);

    // R9 / R10: cancel mid-conversion
    convert(8'h3C);
    @(posedge clk); #1 target = 8'hC3; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (14) @(posedge clk);
    #1 stby = 1'b1;
    #0.5 chk("R9 flag immediate", int'(status), 1);
    @(posedge clk); #3 chk("R9 dac cleared", int'(dac), 0);
    @(posedge clk); #1 stby = 1'b0;
    read_chk("R10 result kept", 8'h3C);
    convert(8'hC3);
    read_chk("R9 recovery", 8'hC3);

    // R11: read during a conversion
    sel = 3'd5;
    @(posedge clk); #1 target = 8'd9; start = 1'b1; rd_en = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (6) @(posedge clk);
    #2 chk("R11 selection id", int'(bus), 5);
    #1 sel = 3'd2;
    @(posedge clk); #2 chk("R11 selection id", int'(bus), 2);
    repeat (35) @(posedge clk);
    #2 chk("R12 result after done", int'(bus), 9);
    #1 rd_en = 1'b0;
    @(posedge clk); #2 chk("R12 idle bus", int'(bus), 0);

    // R6: full sweep, equality and monotonicity
    prev = -1;
    for (int v = 0; v < 256; v++) begin
      convert(v[7:0]);
      @(posedge clk); #1 rd_en = 1'b1;
      #2 chk("R6 code", int'(bus), v);
      chk("R6 monotonic", int'(int'(bus) > prev), 1);
      prev = int'(bus);
      @(posedge clk); #1 rd_en = 1'b0;
    end

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule